// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the per-beat column sequence for read and write bursts in an SDRAM controller or memory model. A read or write command strobe starts a burst at the supplied start column. The column for the first beat is presented in the same cycle as the command. The following beats come one per cycle, ordered by the programmed burst type. The block also gives the write-data enable after the data mask has been applied, and the read-data output enable, which is delayed by the CAS latency and gated by the mask with its own latency.

The mode inputs carry the burst length code, the ordering, the CAS latency and the single-write option. The length code, the ordering and the single-write option are captured when a command arrives. The CAS latency is used live, so it must be held stable while read data is still in flight. The storage array and the bank state are outside this block. Any new read or write cuts off the running burst, and a stop strobe (burst terminate or precharge) ends it.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is low and after it is released with no command pending, `beat_valid`, `beat_last`, `wr_en` and `rd_oe` are all low.
- R2: Burst length code `mode_bl` maps 0→1, 1→2, 2→4, 3→8 beats and 7→full page; codes 4..6 act as one beat. A burst raises `beat_valid` for exactly that many consecutive cycles, starting in the command cycle, and `beat_last` is high only on its final beat.
- R3: With `mode_ilv`=0, beat i has column `base + ((s mod L) + i) mod L`, where s is the start column, L the burst length and base = s − (s mod L). For example, start 5 with L=8 gives 5,6,7,0,1,2,3,4.
- R4: With `mode_ilv`=1, beat i has column `base + ((s mod L) XOR i)`. For example, start 5 with L=8 gives 5,4,7,6,1,0,3,2.
- R5: A full-page burst counts `(s + i) mod 512` and always uses sequential order, even when `mode_ilv`=1. It never raises `beat_last` and runs until it is stopped or interrupted.
- R6: `stop_cmd` ends the running burst. `beat_valid` is low in the stop cycle and stays low until the next command.
- R7: A read or write command, including one issued while a burst is running, makes that cycle beat 0 at its own start column. At most one of `rd_cmd`, `wr_cmd` and `stop_cmd` may be high in a cycle.
- R8: Each read beat in cycle t raises `rd_oe` in cycle t+CL, where CL is `mode_cl` (1..3; 0 acts as 1). So a stop at cycle t removes output from cycle t+CL onward.
- R9: `dqm` high in cycle t forces `rd_oe` low in cycle t+2.
- R10: `wr_en` is high exactly in the cycles that carry a write beat with `dqm` low in that same cycle.
- R11: A write command at cycle w forces `rd_oe` low from cycle w+1 for every read beat issued before w.
- R12: With `mode_single_wr`=1, a write burst is one beat long whatever `mode_bl` holds, while reads keep the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_bl | input | 3 | Burst length code (captured at command) |
| mode_ilv | input | 1 | 1 = XOR interleaved order, 0 = sequential (captured) |
| mode_cl | input | 2 | CAS latency in cycles, 1..3 |
| mode_single_wr | input | 1 | Writes use one beat (captured) |
| rd_cmd | input | 1 | Read command strobe |
| wr_cmd | input | 1 | Write command strobe |
| stop_cmd | input | 1 | Burst terminate or precharge strobe |
| start_col | input | 9 | Start column for the command |
| dqm | input | 1 | Data mask |
| col | output | 9 | Column of the current beat |
| beat_valid | output | 1 | A beat is taking place this cycle |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| wr_en | output | 1 | Write data is accepted this cycle |
| rd_oe | output | 1 | Read data is driven this cycle |

## Verification
`col`, `beat_valid`, `beat_last` and `wr_en` are due in the same cycle as the command or beat that causes them, and the first beat is due in the command cycle itself. `rd_oe` is due CL cycles after each read beat. A mask takes effect two cycles later, and a write blocks earlier reads from the following cycle. The bench samples every output at the falling edge of each cycle. It compares them with values derived from a small per-cycle history of read beats, write commands and mask values, kept in a ring indexed by cycle number. This lets each delayed result be looked up at exactly its due cycle.

// File: rtl/burst_pkg.sv
// Package: shared constants and helpers for the burst column generator.
// Assumes a burst length code of 3 bits.
package burst_pkg;

    // Length code that selects a full-page burst
    localparam logic [2:0] BL_CODE_FULL = 3'b111;

    // log2 of the burst length for a fixed-length code; reserved codes give one beat
    function automatic logic [2:0] len_log2(input logic [2:0] code);
        return (code <= 3'd3) ? code : 3'd0;
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Tracks the running burst: beat index, captured start column, length mask
// and ordering. Beat 0 is presented combinationally in the command cycle;
// later beats come from registers. Assumes at most one strobe per cycle and
// COL_W of at least 4.
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cmd,
    input  logic             wr_cmd,
    input  logic             stop_cmd,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_code,
    input  logic             ilv,
    input  logic             single_wr,
    output logic             beat_valid,
    output logic             beat_last,
    output logic             beat_wr,
    output logic [COL_W-1:0] beat_start,
    output logic [COL_W-1:0] beat_idx,
    output logic [COL_W-1:0] beat_mask,
    output logic             beat_ilv
);

    logic             new_cmd;
    logic             use_single;
    logic             full_new;
    logic             ilv_new;
    logic [2:0]       k_new;
    logic [COL_W-1:0] mask_new;
    logic             full_sel;

    logic             act_q;
    logic             wr_q;
    logic             full_q;
    logic             ilv_q;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] mask_q;

    // Decode the length and ordering that a command arriving now would use
    always_comb begin
        new_cmd    = rd_cmd || wr_cmd;
        use_single = wr_cmd && single_wr;
        full_new   = (bl_code == BL_CODE_FULL) && !use_single;
        k_new      = use_single ? 3'd0 : len_log2(bl_code);
        mask_new   = full_new ? '1 : ((COL_W'(1) << k_new) - COL_W'(1));
        ilv_new    = ilv && !full_new;
    end

    // Present beat 0 live on a command, otherwise the registered burst
    always_comb begin
        if (new_cmd) begin
            beat_valid = 1'b1;
            beat_wr    = wr_cmd;
            beat_start = start_col;
            beat_idx   = '0;
            beat_mask  = mask_new;
            beat_ilv   = ilv_new;
            full_sel   = full_new;
        end else begin
            beat_valid = act_q && !stop_cmd;
            beat_wr    = wr_q;
            beat_start = start_q;
            beat_idx   = idx_q;
            beat_mask  = mask_q;
            beat_ilv   = ilv_q;
            full_sel   = full_q;
        end
        beat_last = beat_valid && !full_sel && (beat_idx == beat_mask);
    end

    // Capture a new burst, advance the beat index, or end the burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            wr_q    <= 1'b0;
            full_q  <= 1'b0;
            ilv_q   <= 1'b0;
            start_q <= '0;
            idx_q   <= '0;
            mask_q  <= '0;
        end else if (new_cmd) begin
            act_q   <= !beat_last;
            wr_q    <= wr_cmd;
            full_q  <= full_new;
            ilv_q   <= ilv_new;
            start_q <= start_col;
            idx_q   <= COL_W'(1);
            mask_q  <= mask_new;
        end else if (act_q) begin
            if (stop_cmd || beat_last) begin
                act_q <= 1'b0;
            end else begin
                idx_q <= idx_q + COL_W'(1);
            end
        end
    end

    AST_BURST_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> (beat_valid || stop_cmd)); // R2

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |=> (!beat_valid || rd_cmd || wr_cmd)); // R2

    AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && !rd_cmd && !wr_cmd) |=> (!beat_valid || rd_cmd || wr_cmd)); // R6

endmodule

// File: rtl/burst_col_map.sv
// Module: burst_col_map
// Maps the start column and beat index to the beat's column. The bits above
// the length mask come from the start column; the bits under it either count
// up with wrap (sequential) or are XORed with the index (interleaved).
// Assumes the mask is 2^k-1 and the index stays below 2^k.
module burst_col_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] beat_start,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] beat_mask,
    input  logic             beat_ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    // Combine the fixed upper bits with the ordered lower bits
    always_comb begin
        low_seq = beat_start + beat_idx;
        low_ilv = beat_start ^ beat_idx;
        col     = (beat_start & ~beat_mask) | ((beat_ilv ? low_ilv : low_seq) & beat_mask);
    end

endmodule

// File: rtl/burst_rd_pipe.sv
// Module: burst_rd_pipe
// Delays read beats by the CAS latency to form the output enable, applies the
// two-cycle mask delay, and flushes earlier reads when a write arrives.
// Assumes the latency input is held stable while reads are in flight.
module burst_rd_pipe #(
    parameter int MAX_CL = 3,
    localparam int CL_W  = $clog2(MAX_CL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_beat,
    input  logic            wr_cmd,
    input  logic            dqm,
    input  logic [CL_W-1:0] cas_lat,
    output logic            rd_oe
);

    logic [MAX_CL-1:0] stage_q;
    logic [1:0]        dqm_q;
    logic [CL_W-1:0]   tap;

    // Choose the stage that matches the latency; 0 acts as 1, clamp above max
    always_comb begin
        if (cas_lat == '0) begin
            tap = '0;
        end else if (int'(cas_lat) > MAX_CL) begin
            tap = CL_W'(MAX_CL - 1);
        end else begin
            tap = cas_lat - CL_W'(1);
        end
        rd_oe = stage_q[tap] && !dqm_q[1];
    end

    // Shift read beats along; a write clears every read already in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr_cmd) begin
            stage_q <= '0;
        end else begin
            stage_q <= (stage_q << 1) | MAX_CL'(rd_beat);
        end
    end

    // Delay the mask by two cycles for the read output path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dqm_q <= '0;
        end else begin
            dqm_q <= {dqm_q[0], dqm};
        end
    end

    AST_WR_KILLS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> !rd_oe); // R11

    AST_DQM_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dqm, 2) |-> !rd_oe); // R9

endmodule

// File: rtl/burst_col_gen.sv
// Module: burst_col_gen (top)
// Per-beat column generator for SDRAM read and write bursts, with the write
// enable after masking and the CAS-latency-delayed read output enable.
// Assumes at most one of the read, write and stop strobes per cycle.
module burst_col_gen #(
    parameter int COL_W  = 9,
    parameter int MAX_CL = 3,
    localparam int CL_W  = $clog2(MAX_CL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_bl,
    input  logic             mode_ilv,
    input  logic [CL_W-1:0]  mode_cl,
    input  logic             mode_single_wr,
    input  logic             rd_cmd,
    input  logic             wr_cmd,
    input  logic             stop_cmd,
    input  logic [COL_W-1:0] start_col,
    input  logic             dqm,
    output logic [COL_W-1:0] col,
    output logic             beat_valid,
    output logic             beat_last,
    output logic             wr_en,
    output logic             rd_oe
);

    logic             beat_wr;
    logic [COL_W-1:0] beat_start;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] beat_mask;
    logic             beat_ilv;
    logic             rd_beat;

    burst_beat_ctr #(.COL_W(COL_W)) i_beat_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cmd     (rd_cmd),
        .wr_cmd     (wr_cmd),
        .stop_cmd   (stop_cmd),
        .start_col  (start_col),
        .bl_code    (mode_bl),
        .ilv        (mode_ilv),
        .single_wr  (mode_single_wr),
        .beat_valid (beat_valid),
        .beat_last  (beat_last),
        .beat_wr    (beat_wr),
        .beat_start (beat_start),
        .beat_idx   (beat_idx),
        .beat_mask  (beat_mask),
        .beat_ilv   (beat_ilv)
    );

    burst_col_map #(.COL_W(COL_W)) i_col_map (
        .beat_start (beat_start),
        .beat_idx   (beat_idx),
        .beat_mask  (beat_mask),
        .beat_ilv   (beat_ilv),
        .col        (col)
    );

    // Split beats into masked write acceptance and read pipeline input
    always_comb begin
        wr_en   = beat_valid && beat_wr && !dqm;
        rd_beat = beat_valid && !beat_wr;
    end

    burst_rd_pipe #(.MAX_CL(MAX_CL)) i_rd_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_beat (rd_beat),
        .wr_cmd  (wr_cmd),
        .dqm     (dqm),
        .cas_lat (mode_cl),
        .rd_oe   (rd_oe)
    );

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_cmd, wr_cmd, stop_cmd})); // R7

    AST_WR_ZERO_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !dqm) |-> wr_en); // R10

endmodule

// File: tb/test_burst_col_gen.sv
// Bench: directed corner cases plus seeded random traffic, checked every
// cycle at the falling edge against a bench-side cycle model.
module test_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_bl = 3'd0;
    logic       mode_ilv = 1'b0;
    logic [1:0] mode_cl = 2'd2;
    logic       mode_single_wr = 1'b0;
    logic       rd_cmd = 1'b0;
    logic       wr_cmd = 1'b0;
    logic       stop_cmd = 1'b0;
    logic [8:0] start_col = 9'd0;
    logic       dqm = 1'b0;
    logic [8:0] col;
    logic       beat_valid;
    logic       beat_last;
    logic       wr_en;
    logic       rd_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_col_gen i_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .mode_bl(mode_bl), .mode_ilv(mode_ilv),
        .mode_cl(mode_cl), .mode_single_wr(mode_single_wr), .rd_cmd(rd_cmd),
        .wr_cmd(wr_cmd), .stop_cmd(stop_cmd), .start_col(start_col), .dqm(dqm),
        .col(col), .beat_valid(beat_valid), .beat_last(beat_last),
        .wr_en(wr_en), .rd_oe(rd_oe)
    );

    // model state
    int cyc = 8;
    bit m_act = 0, m_wr = 0, m_full = 0, m_ilv = 0;
    int m_len = 1, m_start = 0, m_idx = 0;
    bit beat_h[8];
    bit wrc_h[8];
    bit dqm_h[8];

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic int len_of(int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int ref_col(int s, int i, int len, bit il, bit full);
        int off;
        if (full) return (s + i) % 512;
        off = s % len;
        if (il) return (s - off) + (off ^ i);
        return (s - off) + ((off + i) % len);
    endfunction

    // Check all outputs for the current cycle, then advance the model
    task automatic model_cycle();
        bit cmd, ev, el, ewr, eoe, killed, single, full, il, stop_eff;
        int ecol, len, cl;
        string vtag, ctag, otag;
        cmd = rd_cmd || wr_cmd;
        stop_eff = 0;
        ecol = 0; ev = 0; el = 0; ewr = 0; vtag = "R2"; ctag = "R3";
        if (cmd) begin
            single = wr_cmd && mode_single_wr;
            full   = (mode_bl == 3'd7) && !single;
            len    = single ? 1 : len_of(int'(mode_bl));
            il     = mode_ilv && !full;
            ev = 1; ewr = wr_cmd; ecol = start_col;
            el = !full && (len == 1);
            vtag = single ? "R12" : "R7"; ctag = "R7";
            m_wr = wr_cmd; m_full = full; m_ilv = il; m_len = len;
            m_start = start_col; m_idx = 1; m_act = !el;
        end else if (m_act && !stop_cmd) begin
            ev = 1; ewr = m_wr;
            ecol = ref_col(m_start, m_idx, m_len, m_ilv, m_full);
            el = !m_full && (m_idx == m_len - 1);
            ctag = m_full ? "R5" : (m_ilv ? "R4" : "R3");
            if (el) m_act = 0;
            else m_idx = m_full ? (m_idx + 1) % 512 : m_idx + 1;
        end else begin
            if (stop_cmd && m_act) begin vtag = "R6"; stop_eff = 1; end
            m_act = 0;
        end
        cl = (mode_cl == 0) ? 1 : int'(mode_cl);
        killed = 0;
        for (int w = cyc - cl + 1; w <= cyc - 1; w++) if (wrc_h[w % 8]) killed = 1;
        eoe = beat_h[(cyc - cl) % 8] && !dqm_h[(cyc - 2) % 8] && !killed;
        otag = killed ? "R11" : (dqm_h[(cyc - 2) % 8] ? "R9" : "R8");

        chk(vtag, "beat_valid", int'(beat_valid), int'(ev));
        if (ev) chk(ctag, "col", int'(col), ecol);
        chk(stop_eff ? "R6" : "R2", "beat_last", int'(beat_last), int'(el));
        chk("R10", "wr_en", int'(wr_en), int'(ev && ewr && !dqm));
        chk(otag, "rd_oe", int'(rd_oe), int'(eoe));

        beat_h[cyc % 8] = ev && !ewr;
        wrc_h[cyc % 8]  = wr_cmd;
        dqm_h[cyc % 8]  = dqm;
        cyc++;
    endtask

    task automatic tick();
        @(negedge clk);
        model_cycle();
        @(posedge clk);
        #1;
        rd_cmd = 0; wr_cmd = 0; stop_cmd = 0; dqm = 0;
    endtask

    task automatic issue(bit rd, bit wr, int s, int bl, bit il);
        rd_cmd = rd; wr_cmd = wr; start_col = 9'(s); mode_bl = 3'(bl); mode_ilv = il;
        tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        for (int i = 0; i < 8; i++) begin beat_h[i] = 0; wrc_h[i] = 0; dqm_h[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet in reset
        @(negedge clk);
        chk("R1", "beat_valid in reset", int'(beat_valid), 0);
        chk("R1", "rd_oe in reset", int'(rd_oe), 0);
        chk("R1", "wr_en in reset", int'(wr_en), 0);
        @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        chk("R1", "beat_last after reset", int'(beat_last), 0);
        @(posedge clk); #1;
        idle(2);

        // R3: start 5, BL8 sequential read, CL2
        mode_cl = 2'd2;
        issue(1, 0, 5, 3, 0);
        idle(10);
        // R4: start 5, BL8 interleaved read
        issue(1, 0, 5, 3, 1);
        idle(10);
        // R2: reserved code behaves as one beat; BL4 write with mask (R10)
        issue(0, 1, 13, 5, 0);
        dqm = 1;
        issue(0, 1, 22, 2, 0);
        idle(1);
        dqm = 1;
        idle(4);
        // R9: mask during a read, CL3
        mode_cl = 2'd3;
        issue(1, 0, 40, 3, 0);
        tick();
        dqm = 1;
        idle(10);
        // R11: write interrupts read
        issue(1, 0, 100, 3, 0);
        idle(1);
        issue(0, 1, 200, 2, 0);
        idle(8);
        // R5: full page with interleave request, wraps past 511, then stop (R6)
        issue(1, 0, 500, 7, 1);
        idle(30);
        stop_cmd = 1;
        tick();
        idle(6);
        // R12: single write ignores length; read keeps it
        mode_single_wr = 1;
        issue(0, 1, 7, 3, 0);
        idle(2);
        issue(1, 0, 7, 2, 0);
        idle(6);
        mode_single_wr = 0;
        // R8: stop after two read beats with CL1
        mode_cl = 2'd1;
        issue(1, 0, 3, 3, 0);
        tick();
        stop_cmd = 1;
        tick();
        idle(6);

        // random phases over each latency
        for (int ph = 1; ph <= 3; ph++) begin
            mode_cl = 2'(ph);
            for (int i = 0; i < 2500; i++) begin
                int r;
                int pick;
                r = int'($urandom % 16);
                pick = int'($urandom % 6);
                mode_bl = (pick == 4) ? 3'd7 : ((pick == 5) ? 3'd6 : 3'(pick));
                mode_ilv = 1'($urandom % 2);
                mode_single_wr = ($urandom % 4) == 0;
                start_col = 9'($urandom % 512);
                dqm = ($urandom % 4) == 0;
                rd_cmd = (r < 2);
                wr_cmd = (r == 2);
                stop_cmd = (r == 3);
                tick();
            end
            stop_cmd = 1;
            tick();
            idle(6);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule